// File: doc/BRIEF.md
# Time-Stamping Address-Event Monitor

This block sits on the merged output of an address-event arbiter. It completes a four-phase request/acknowledge handshake for every event offered to it. When capture is on and the event's channel is not masked, it writes the 16-bit event address into a downstream FIFO write port. It can follow the address with the value of a 32-bit time counter that runs inside the block. Every stored word carries an 18-bit format: a 2-bit type tag on top and a 16-bit payload below. A reader that loses its place can therefore find the next address word again.

The time counter advances once per tick, and the tick comes from a prescaler on the core clock. It can be frozen, and a synchronous clear holds it at zero. Two sticky interrupt flags record when the FIFO occupancy reaches half and when it reaches full. The host clears them with a write-one mask that is not stored.

A multi-word event is never split. If the free space cannot hold the whole burst, the event is dropped and counted. A single error word reporting the count is written as soon as one slot is free.

The FIFO write port uses valid/ready. `wr_data` is presented with `wr_valid` and stays unchanged until a cycle with `wr_ready` high accepts it. Words of a burst follow each other with no gaps when `wr_ready` stays high. The request handshake is only back-pressured while a previous burst or the error word is still being written. Lack of FIFO space never stalls it.

Top module: `aer_evmon`

## Requirements
- R1: `ev_ack` rises in response to `ev_req` high and stays high while the request is held. It falls one cycle after the (synchronised) request falls. Each handshake captures at most one event.
- R2: An address word has tag 2'b00 in bits 17:16 and the event address in bits 15:0.
- R3: With `time_lbl_en`=1 an accepted event writes three consecutive words in this order: address, then tag 2'b01 with time bits 31:16, then tag 2'b10 with time bits 15:0. The time is the counter value on the cycle the event is accepted.
- R4: With `time_lbl_en`=0 an accepted event writes only its address word.
- R5: The channel is the event address bits 15:14. If `chan_mask` bit [channel] is 1 the event is acknowledged but nothing is written. If the bit is 0 the event is recorded.
- R6: With `cap_en`=0 every event is acknowledged and nothing is written.
- R7: With `sync_en`=1 the request passes through two flip-flops and `ev_ack` rises on the third clock edge after the request rises. With `sync_en`=0 it rises on the first edge.
- R8: `tick_sel` values 0, 1, 2 and 3 give a tick period of 1, 10, 50 and 100 µs, i.e. CYC_PER_US times that many clock cycles. After k enabled cycles from a cleared state, `time_value` equals k divided by the period, rounded down.
- R9: While `time_clr`=1 the counter and prescaler are held at zero. While `time_en`=0 the counter keeps its value.
- R10: An event that needs more words than the FIFO has free (DEPTH minus `fifo_count`), or that arrives while an error report is pending, is dropped whole. The dropped events are counted, saturating at 16 bits. When at least one slot is free and no burst is active, one word with tag 2'b11 and that count as payload is written and the count restarts at zero.
- R11: `irq_half` is set when `fifo_count` reaches DEPTH/2 from below. `irq_full` is set when it reaches DEPTH from below. Both stay set until cleared.
- R12: A cycle with `clr_we`=1 clears `irq_half` if `clr_mask` bit 0 is 1 and `irq_full` if bit 1 is 1. The other flag is unchanged. A flag being set in the same cycle wins over the clear.
- R13: While `wr_valid` is high and `wr_ready` is low, `wr_valid` stays high and `wr_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_req | input | 1 | Event request from the arbiter |
| ev_addr | input | 16 | Event address, valid while `ev_req` is high |
| ev_ack | output | 1 | Event acknowledge |
| cap_en | input | 1 | 1 = capture events |
| time_lbl_en | input | 1 | 1 = append time words to each event |
| chan_mask | input | 4 | Per-channel ignore bits, 1 = ignore |
| sync_en | input | 1 | 1 = two-stage synchroniser on `ev_req` |
| tick_sel | input | 2 | Tick period select (1/10/50/100 µs) |
| time_en | input | 1 | 1 = time counter runs |
| time_clr | input | 1 | 1 = hold time counter at zero |
| time_value | output | 32 | Current time counter |
| wr_valid | output | 1 | FIFO write word valid |
| wr_ready | input | 1 | FIFO accepts the word |
| wr_data | output | 18 | Tagged FIFO word |
| fifo_count | input | $clog2(DEPTH+1) | FIFO occupancy in words (5 bits at default) |
| irq_half | output | 1 | Sticky half-full flag |
| irq_full | output | 1 | Sticky full flag |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 2 | Bit 0 clears `irq_half`, bit 1 clears `irq_full` |

## Verification
A handshake state stuck in the acknowledge state shows as `ev_ack` failing to fall one cycle after the request drops, so the next event hangs at once. A writer state that skips or repeats a step shows within the next burst as a wrong tag sequence or a wrong word count. A lost-event count that is off, or an error word that is never released, appears on the first drain after an overflow, as a wrong tag 2'b11 payload or a missing word. Prescaler or flag-edge errors show as a wrong `time_value` after a known number of cycles, or as a flag that re-asserts after a clear while the level has not changed.

// File: rtl/aer_evmon_pkg.sv
package aer_evmon_pkg;
  localparam int PAY_W  = 16;
  localparam int TAG_W  = 2;
  localparam int WORD_W = PAY_W + TAG_W;
  localparam int TS_W   = 32;
  localparam int NCH    = 4;
  localparam int CH_W   = $clog2(NCH);

  typedef enum logic [TAG_W-1:0] {
    TAG_ADDR = 2'b00,
    TAG_THI  = 2'b01,
    TAG_TLO  = 2'b10,
    TAG_ERR  = 2'b11
  } tag_e;
endpackage

// File: rtl/aer_evmon_sync.sv
module aer_evmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_en,
  input  logic req_in,
  output logic req_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= req_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign req_out = sync_en ? chain_q[STAGES-1] : req_in;
endmodule

// File: rtl/aer_evmon_timer.sv
module aer_evmon_timer
  import aer_evmon_pkg::*;
#(
  parameter int CYC_PER_US = 125
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            time_en,
  input  logic            time_clr,
  input  logic [1:0]      tick_sel,
  output logic [TS_W-1:0] count
);
  localparam int LIM0 = CYC_PER_US * 1;
  localparam int LIM1 = CYC_PER_US * 10;
  localparam int LIM2 = CYC_PER_US * 50;
  localparam int LIM3 = CYC_PER_US * 100;
  localparam int PW   = $clog2(LIM3 + 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim_m1;
  logic          tick;

  always_comb begin
    case (tick_sel)
      2'd0:    lim_m1 = PW'(LIM0 - 1);
      2'd1:    lim_m1 = PW'(LIM1 - 1);
      2'd2:    lim_m1 = PW'(LIM2 - 1);
      default: lim_m1 = PW'(LIM3 - 1);
    endcase
  end

  assign tick = time_en && (pre_q >= lim_m1);

  always_ff @(posedge clk) begin
    if (!rst_n || time_clr) begin
      pre_q <= '0;
      count <= '0;
    end else if (time_en) begin
      if (tick) begin
        pre_q <= '0;
        count <= count + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    time_clr |=> (count == '0)); // R9
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!time_en && !time_clr) |=> $stable(count)); // R9
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (time_en && !time_clr) |=> (count == $past(count) || count == $past(count) + 1'b1)); // R8
endmodule

// File: rtl/aer_evmon_flags.sv
module aer_evmon_flags #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] fifo_count,
  input  logic          clr_we,
  input  logic [1:0]    clr_mask,
  output logic          irq_half,
  output logic          irq_full
);
  localparam int HALF = DEPTH / 2;

  logic half_lvl, full_lvl;
  logic half_prev, full_prev;

  assign half_lvl = (fifo_count >= CW'(HALF));
  assign full_lvl = (fifo_count >= CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_prev <= 1'b1;
      full_prev <= 1'b1;
      irq_half  <= 1'b0;
      irq_full  <= 1'b0;
    end else begin
      half_prev <= half_lvl;
      full_prev <= full_lvl;
      if (half_lvl && !half_prev)      irq_half <= 1'b1;
      else if (clr_we && clr_mask[0])  irq_half <= 1'b0;
      if (full_lvl && !full_prev)      irq_full <= 1'b1;
      else if (clr_we && clr_mask[1])  irq_full <= 1'b0;
    end
  end

  AST_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(full_lvl) && full_prev == 1'b0) |=> irq_full); // R11
  AST_HALF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_mask[0] && !(half_lvl && !half_prev)) |=> !irq_half); // R12
  AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_full && !(clr_we && clr_mask[1])) |=> irq_full); // R11
endmodule

// File: rtl/aer_evmon_writer.sv
module aer_evmon_writer
  import aer_evmon_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAY_W-1:0]  start_addr,
  input  logic [TS_W-1:0]   start_time,
  input  logic              start_lbl,
  input  logic              drop_nofit,
  input  logic [CW-1:0]     fifo_free,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_data,
  output logic              accept_ok,
  output logic              err_pend
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_THI, S_TLO, S_ERR} wst_e;

  wst_e              st;
  logic [PAY_W-1:0]  lost_q;
  logic [TS_W-1:0]   time_q;
  logic              lbl_q;
  logic              err_go;

  assign err_pend  = (lost_q != '0);
  assign err_go    = (st == S_IDLE) && err_pend && (fifo_free != '0);
  assign accept_ok = (st == S_IDLE) && !err_go;
  assign wr_valid  = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      wr_data <= '0;
      lost_q  <= '0;
      time_q  <= '0;
      lbl_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (err_go) begin
            wr_data <= {TAG_ERR, lost_q};
            lost_q  <= '0;
            st      <= S_ERR;
          end else if (start) begin
            wr_data <= {TAG_ADDR, start_addr};
            time_q  <= start_time;
            lbl_q   <= start_lbl;
            st      <= S_ADDR;
          end else if (drop_nofit && lost_q != '1) begin
            lost_q <= lost_q + 1'b1;
          end
        end
        S_ADDR: if (wr_ready) begin
          if (lbl_q) begin
            wr_data <= {TAG_THI, time_q[TS_W-1:PAY_W]};
            st      <= S_THI;
          end else begin
            st <= S_IDLE;
          end
        end
        S_THI: if (wr_ready) begin
          wr_data <= {TAG_TLO, time_q[PAY_W-1:0]};
          st      <= S_TLO;
        end
        S_TLO: if (wr_ready) st <= S_IDLE;
        S_ERR: if (wr_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data))); // R13
  AST_HI_THEN_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_data[WORD_W-1:PAY_W] == TAG_THI)
      |=> (wr_valid && wr_data[WORD_W-1:PAY_W] == TAG_TLO)); // R3
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start || drop_nofit) |-> !wr_valid); // R1
endmodule

// File: rtl/aer_evmon.sv
module aer_evmon
  import aer_evmon_pkg::*;
#(
  parameter int CYC_PER_US  = 125,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CW          = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_req,
  input  logic [PAY_W-1:0]  ev_addr,
  output logic              ev_ack,
  input  logic              cap_en,
  input  logic              time_lbl_en,
  input  logic [NCH-1:0]    chan_mask,
  input  logic              sync_en,
  input  logic [1:0]        tick_sel,
  input  logic              time_en,
  input  logic              time_clr,
  output logic [TS_W-1:0]   time_value,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [WORD_W-1:0] wr_data,
  input  logic [CW-1:0]     fifo_count,
  output logic              irq_half,
  output logic              irq_full,
  input  logic              clr_we,
  input  logic [1:0]        clr_mask
);
  typedef enum logic {HS_IDLE, HS_ACK} hs_e;

  hs_e            hs_st;
  logic           req_s;
  logic           accept_ok, err_pend;
  logic           hs_take, want, fits, start, drop_nofit;
  logic [CH_W-1:0] ch;
  logic [CW-1:0]  fifo_free, need;

  aer_evmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .req_in(ev_req), .req_out(req_s)
  );

  aer_evmon_timer #(.CYC_PER_US(CYC_PER_US)) u_timer (
    .clk(clk), .rst_n(rst_n), .time_en(time_en), .time_clr(time_clr),
    .tick_sel(tick_sel), .count(time_value)
  );

  aer_evmon_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
    .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count), .clr_we(clr_we),
    .clr_mask(clr_mask), .irq_half(irq_half), .irq_full(irq_full)
  );

  assign ch         = ev_addr[PAY_W-1 -: CH_W];
  assign fifo_free  = CW'(DEPTH) - fifo_count;
  assign need       = time_lbl_en ? CW'(3) : CW'(1);
  assign hs_take    = (hs_st == HS_IDLE) && req_s && accept_ok;
  assign want       = cap_en && !chan_mask[ch];
  assign fits       = !err_pend && (fifo_free >= need);
  assign start      = hs_take && want && fits;
  assign drop_nofit = hs_take && want && !fits;

  aer_evmon_writer #(.CW(CW)) u_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(ev_addr),
    .start_time(time_value), .start_lbl(time_lbl_en), .drop_nofit(drop_nofit),
    .fifo_free(fifo_free), .wr_ready(wr_ready), .wr_valid(wr_valid),
    .wr_data(wr_data), .accept_ok(accept_ok), .err_pend(err_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_st  <= HS_IDLE;
      ev_ack <= 1'b0;
    end else begin
      case (hs_st)
        HS_IDLE: if (hs_take) begin
          ev_ack <= 1'b1;
          hs_st  <= HS_ACK;
        end
        HS_ACK: if (!req_s) begin
          ev_ack <= 1'b0;
          hs_st  <= HS_IDLE;
        end
        default: hs_st <= HS_IDLE;
      endcase
    end
  end

  AST_ACK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack && !req_s) |=> !ev_ack); // R1
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack && req_s) |=> ev_ack); // R1
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_take && (!cap_en || chan_mask[ch]) && !wr_valid) |=> !wr_valid); // R5
endmodule

// File: tb/aer_evmon_tb.sv
`timescale 1ns/1ps
module aer_evmon_tb;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_req;
  logic [15:0] ev_addr;
  logic        ev_ack;
  logic        cap_en, time_lbl_en, sync_en, time_en, time_clr;
  logic [3:0]  chan_mask;
  logic [1:0]  tick_sel;
  logic [31:0] time_value;
  logic        wr_valid, wr_ready;
  logic [17:0] wr_data;
  logic [CW-1:0] fifo_count;
  logic        irq_half, irq_full, clr_we;
  logic [1:0]  clr_mask;

  int          total = 0;
  int          bad = 0;
  bit          finished = 0;
  int          cnt;
  int          log_n;
  logic [17:0] wlog [0:63];
  logic        pop, stall;
  bit          last_ack;

  always #4 clk = ~clk;

  aer_evmon #(.CYC_PER_US(4), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_req(ev_req), .ev_addr(ev_addr), .ev_ack(ev_ack),
    .cap_en(cap_en), .time_lbl_en(time_lbl_en), .chan_mask(chan_mask),
    .sync_en(sync_en), .tick_sel(tick_sel), .time_en(time_en), .time_clr(time_clr),
    .time_value(time_value), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .fifo_count(fifo_count), .irq_half(irq_half),
    .irq_full(irq_full), .clr_we(clr_we), .clr_mask(clr_mask)
  );

  assign wr_ready   = (cnt < DEPTH) && !stall;
  assign fifo_count = CW'(cnt);

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= 0;
      log_n <= 0;
    end else begin
      if (wr_valid && wr_ready) begin
        wlog[log_n[5:0]] <= wr_data;
        log_n <= log_n + 1;
      end
      cnt <= cnt + ((wr_valid && wr_ready) ? 1 : 0) - ((pop && cnt > 0) ? 1 : 0);
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FIAL_MARK");
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ev_req = 1'b0; ev_addr = '0; cap_en = 1'b1; time_lbl_en = 1'b1;
    chan_mask = '0; sync_en = 1'b0; tick_sel = '0; time_en = 1'b0; time_clr = 1'b0;
    clr_we = 1'b0; clr_mask = '0; pop = 1'b0; stall = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_ev(input logic [15:0] a);
    int n;
    @(negedge clk);
    ev_addr = a; ev_req = 1'b1;
    n = 0;
    while (!ev_ack && n < 20) begin @(negedge clk); n++; end
    last_ack = ev_ack;
    ev_req = 1'b0;
    n = 0;
    while (ev_ack && n < 20) begin @(negedge clk); n++; end
    repeat (6) @(negedge clk);
  endtask

  task automatic run_timer(input int k);
    @(negedge clk);
    time_clr = 1'b1;
    repeat (2) @(negedge clk);
    time_clr = 1'b0; time_en = 1'b1;
    repeat (k) @(posedge clk);
    @(negedge clk);
    time_en = 1'b0;
  endtask

  task automatic drain(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); pop = 1'b1;
      @(negedge clk); pop = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(ev_ack == 1'b0, "R1", ev_ack, 0);
    chk(wr_valid == 1'b0, "R13", wr_valid, 0);
    chk(irq_half == 1'b0 && irq_full == 1'b0, "R11", {irq_full, irq_half}, 0);
    chk(time_value == 0, "R9", time_value, 0);
  endtask

  task automatic t_timer();
    int lim [4];
    lim[0] = 4; lim[1] = 40; lim[2] = 200; lim[3] = 400;
    do_reset();
    for (int s = 0; s < 4; s++) begin
      tick_sel = 2'(s);
      run_timer(2 * lim[s]);
      chk(time_value == 2, "R8", time_value, 2);
    end
    tick_sel = 2'd0;
    run_timer(41);
    chk(time_value == 10, "R8", time_value, 10);
    repeat (20) @(negedge clk);
    chk(time_value == 10, "R9 frozen", time_value, 10);
    time_clr = 1'b1; time_en = 1'b1;
    repeat (12) @(negedge clk);
    chk(time_value == 0, "R9 clear", time_value, 0);
    time_clr = 1'b0; time_en = 1'b0;
  endtask

  task automatic t_time_words();
    do_reset();
    run_timer(40);
    send_ev(16'h1234);
    chk(log_n == 3, "R3 count", log_n, 3);
    chk(wlog[0] == {2'b00, 16'h1234}, "R2", wlog[0], {2'b00, 16'h1234});
    chk(wlog[1] == {2'b01, 16'h0000}, "R3 hi", wlog[1], {2'b01, 16'h0000});
    chk(wlog[2] == {2'b10, 16'h000A}, "R3 lo", wlog[2], {2'b10, 16'h000A});
  endtask

  task automatic t_no_label();
    do_reset();
    time_lbl_en = 1'b0;
    send_ev(16'hC0DE);
    chk(log_n == 1, "R4 count", log_n, 1);
    chk(wlog[0] == {2'b00, 16'hC0DE}, "R4 word", wlog[0], {2'b00, 16'hC0DE});
  endtask

  task automatic t_mask();
    do_reset();
    chan_mask = 4'b0010;
    send_ev(16'h4123);
    chk(last_ack == 1'b1, "R5 ack", last_ack, 1);
    chk(log_n == 0, "R5 ignored", log_n, 0);
    send_ev(16'h8123);
    chk(log_n == 3 && wlog[0] == {2'b00, 16'h8123}, "R5 kept", wlog[0], {2'b00, 16'h8123});
  endtask

  task automatic t_capoff();
    do_reset();
    cap_en = 1'b0;
    send_ev(16'h0042);
    chk(last_ack == 1'b1, "R6 ack", last_ack, 1);
    chk(log_n == 0, "R6 dropped", log_n, 0);
  endtask

  task automatic t_sync();
    for (int m = 0; m < 2; m++) begin
      int n;
      do_reset();
      sync_en = m[0];
      @(negedge clk);
      ev_addr = 16'h0007; ev_req = 1'b1;
      n = 0;
      while (!ev_ack && n < 10) begin @(posedge clk); n++; @(negedge clk); end
      chk(n == (m == 1 ? 3 : 1), "R7 latency", n, m == 1 ? 3 : 1);
      ev_req = 1'b0;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic t_handshake();
    do_reset();
    time_lbl_en = 1'b0;
    @(negedge clk);
    ev_addr = 16'h0101; ev_req = 1'b1;
    repeat (6) @(negedge clk);
    chk(ev_ack == 1'b1, "R1 held", ev_ack, 1);
    chk(log_n == 1, "R1 once", log_n, 1);
    ev_req = 1'b0;
    @(negedge clk);
    chk(ev_ack == 1'b0, "R1 fall", ev_ack, 0);
  endtask

  task automatic t_backpressure();
    logic [17:0] first;
    do_reset();
    stall = 1'b1;
    send_ev(16'h2222);
    first = wr_data;
    repeat (5) @(negedge clk);
    chk(wr_valid == 1'b1 && wr_data == first, "R13 hold", wr_data, first);
    chk(log_n == 0, "R13 none", log_n, 0);
    stall = 1'b0;
    repeat (6) @(negedge clk);
    chk(log_n == 3 && wlog[0] == {2'b00, 16'h2222}, "R13 release", log_n, 3);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 1; i <= 5; i++) send_ev(16'(i));
    chk(log_n == 15, "R10 fill", log_n, 15);
    chk(irq_half == 1'b1, "R11 half", irq_half, 1);
    chk(irq_full == 1'b0, "R11 notfull", irq_full, 0);
    send_ev(16'h0006);
    chk(log_n == 16 && wlog[15] == {2'b11, 16'h0001}, "R10 err1", wlog[15], {2'b11, 16'h0001});
    chk(irq_full == 1'b1, "R11 full", irq_full, 1);
    send_ev(16'h0007);
    send_ev(16'h0008);
    chk(log_n == 16, "R10 lost", log_n, 16);
    drain(4);
    chk(log_n == 17 && wlog[16] == {2'b11, 16'h0002}, "R10 err2", wlog[16], {2'b11, 16'h0002});
    send_ev(16'h0009);
    chk(log_n == 20 && wlog[17] == {2'b00, 16'h0009}, "R10 fit3", wlog[17], {2'b00, 16'h0009});
    @(negedge clk); clr_we = 1'b1; clr_mask = 2'b01;
    @(negedge clk); clr_we = 1'b0;
    chk(irq_half == 1'b0 && irq_full == 1'b1, "R12 half only", {irq_full, irq_half}, 2);
    @(negedge clk); clr_we = 1'b1; clr_mask = 2'b10;
    @(negedge clk); clr_we = 1'b0;
    repeat (4) @(negedge clk);
    chk(irq_half == 1'b0 && irq_full == 1'b0, "R12 both", {irq_full, irq_half}, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog R1 act=hang exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_timer();
    t_time_words();
    t_no_label();
    t_mask();
    t_capoff();
    t_sync();
    t_handshake();
    t_backpressure();
    t_overflow();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule